// File: doc/BRIEF.md
# Audio Coprocessor Mailbox

This block is a set of byte-wide mailboxes between a main CPU and an audio coprocessor. There are four ports. Each port holds two independent latches, one per direction. The inbound latch is written by the main CPU and read by the coprocessor. The outbound latch is written by the coprocessor and read by the main CPU. Neither side ever reads back its own write.

The coprocessor reaches the ports through a four-byte window of its address space. By default the window starts at 0x00F4, and the two low address bits select the port. The main CPU uses a port select with separate read and write strobes. Read data on both sides is combinational from the latches, and it is zero unless the read is active.

A write to the coprocessor's control register can clear the inbound latches, one half of them at a time. Bit 4 of that write clears inbound ports 0 and 1. Bit 5 clears inbound ports 2 and 3. The clear acts once, at that write, and no state is kept afterwards. Both sides share one clock.

Top module: `audio_mailbox`

## Requirements
- R1: While reset is asserted and after it is released, every inbound and outbound latch reads 0x00.
- R2: A coprocessor write at address 0x00F4+k (k = 0..3) sets outbound latch k. From the next cycle on, a main-CPU read with select k returns the written byte. The other outbound latches are unchanged.
- R3: A main-CPU write with select k sets inbound latch k. From the next cycle on, a coprocessor read at 0x00F4+k returns the written byte, unless a clear hits that port in the same cycle.
- R4: `cop_hit_o` is 1 exactly when the coprocessor address is in 0x00F4..0x00F7. A coprocessor write outside that window changes no latch.
- R5: The two directions are separate. A main-CPU write never changes what the main CPU reads, and a coprocessor write never changes what the coprocessor reads.
- R6: A control write with bit 5 set clears inbound ports 2 and 3 to 0x00. A control write with bit 4 set clears inbound ports 0 and 1 to 0x00. The other control bits have no effect on any latch, and outbound latches are never cleared.
- R7: The clear is one-shot. With no control write, an inbound latch holds its value unless the main CPU writes it. A main-CPU write made in the cycle after a clear lands normally.
- R8: If a main-CPU write and a clear hit the same inbound port in the same cycle, the port ends at 0x00. A main-CPU write to a port in the half that is not cleared still lands.
- R9: `host_rdata_o` is 0x00 while `host_rd_i` is low. `cop_rdata_o` is 0x00 unless `cop_rd_i` is high and the address is inside the window.
- R10: Reads have no side effect: reading the same port twice returns the same value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock shared by both sides |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cop_addr_i | input | 16 | Coprocessor bus address |
| cop_rd_i | input | 1 | Coprocessor read strobe |
| cop_wr_i | input | 1 | Coprocessor write strobe |
| cop_wdata_i | input | 8 | Coprocessor write data |
| cop_rdata_o | output | 8 | Inbound latch of the addressed port, or 0x00 |
| cop_hit_o | output | 1 | Coprocessor address falls in the port window |
| host_sel_i | input | 2 | Main-CPU port select |
| host_rd_i | input | 1 | Main-CPU read strobe |
| host_wr_i | input | 1 | Main-CPU write strobe |
| host_wdata_i | input | 8 | Main-CPU write data |
| host_rdata_o | output | 8 | Outbound latch of the selected port, or 0x00 |
| ctrl_wr_i | input | 1 | Control-register write strobe from the coprocessor |
| ctrl_data_i | input | 8 | Control-register write data (bits 4 and 5 used) |

## Verification
Some behaviours are checked by the assertions on every cycle:
- a write from either side lands in the correct latch;
- latches that nobody addressed keep their value;
- a clear zeroes its half of the inbound latches, including when a main-CPU write hits the same port;
- idle reads return zero.

Other behaviours only the bench scenarios can show:
- the reset values;
- the full end-to-end path from one side's write to the other side's read over every port and many data patterns;
- the exact edges of the address window;
- that reads have no side effect;
- that a write right after a clear lands.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  parameter int unsigned CLR_LO_BIT = 4;  // clears lower half of inbound ports
  parameter int unsigned CLR_HI_BIT = 5;  // clears upper half of inbound ports

  function automatic int unsigned clr_bit_for(int unsigned idx, int unsigned n_ports);
    return (idx >= n_ports / 2) ? CLR_HI_BIT : CLR_LO_BIT;
  endfunction
endpackage

// File: rtl/mbox_decode.sv
module mbox_decode #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned SEL_W = 2,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h00F4
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o,
  output logic [SEL_W-1:0]  idx_o
);
  // window must be aligned to its size
  assign idx_o = addr_i[SEL_W-1:0];
  assign hit_o = (addr_i[ADDR_W-1:SEL_W] == BASE_ADDR[ADDR_W-1:SEL_W]);
endmodule

// File: rtl/mbox_clear.sv
module mbox_clear #(
  parameter int unsigned N_PORTS = 4,
  parameter int unsigned CTRL_W = 8
) (
  input  logic              ctrl_wr_i,
  input  logic [CTRL_W-1:0] ctrl_data_i,
  output logic [N_PORTS-1:0] clr_o
);
  for (genvar g = 0; g < N_PORTS; g++) begin : g_clr
    localparam int unsigned BIT = mbox_pkg::clr_bit_for(g, N_PORTS);
    assign clr_o[g] = ctrl_wr_i & ctrl_data_i[BIT];
  end
endmodule

// File: rtl/mbox_lane.sv
module mbox_lane #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              host_we_i,
  input  logic [DATA_W-1:0] host_wdata_i,
  input  logic              cop_we_i,
  input  logic [DATA_W-1:0] cop_wdata_i,
  input  logic              clr_i,
  output logic [DATA_W-1:0] in_q_o,
  output logic [DATA_W-1:0] out_q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_q_o <= '0;
    end else if (clr_i) begin
      in_q_o <= '0;  // clear beats a same-cycle host write
    end else if (host_we_i) begin
      in_q_o <= host_wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q_o <= '0;
    end else if (cop_we_i) begin
      out_q_o <= cop_wdata_i;
    end
  end
endmodule

// File: rtl/audio_mailbox.sv
module audio_mailbox #(
  parameter int unsigned N_PORTS = 4,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned CTRL_W = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h00F4,
  localparam int unsigned SEL_W = $clog2(N_PORTS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] cop_addr_i,
  input  logic              cop_rd_i,
  input  logic              cop_wr_i,
  input  logic [DATA_W-1:0] cop_wdata_i,
  output logic [DATA_W-1:0] cop_rdata_o,
  output logic              cop_hit_o,
  input  logic [SEL_W-1:0]  host_sel_i,
  input  logic              host_rd_i,
  input  logic              host_wr_i,
  input  logic [DATA_W-1:0] host_wdata_i,
  output logic [DATA_W-1:0] host_rdata_o,
  input  logic              ctrl_wr_i,
  input  logic [CTRL_W-1:0] ctrl_data_i
);
  logic                             cop_hit;
  logic [SEL_W-1:0]                 cop_idx;
  logic [N_PORTS-1:0]               clr;
  logic [N_PORTS-1:0][DATA_W-1:0]   inb_q;
  logic [N_PORTS-1:0][DATA_W-1:0]   outb_q;

  mbox_decode #(
    .ADDR_W   (ADDR_W),
    .SEL_W    (SEL_W),
    .BASE_ADDR(BASE_ADDR)
  ) u_decode (
    .addr_i(cop_addr_i),
    .hit_o (cop_hit),
    .idx_o (cop_idx)
  );

  mbox_clear #(
    .N_PORTS(N_PORTS),
    .CTRL_W (CTRL_W)
  ) u_clear (
    .ctrl_wr_i  (ctrl_wr_i),
    .ctrl_data_i(ctrl_data_i),
    .clr_o      (clr)
  );

  for (genvar g = 0; g < N_PORTS; g++) begin : g_lane
    logic host_we, cop_we;
    assign host_we = host_wr_i && (host_sel_i == SEL_W'(g));
    assign cop_we  = cop_wr_i && cop_hit && (cop_idx == SEL_W'(g));

    mbox_lane #(.DATA_W(DATA_W)) u_lane (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .host_we_i   (host_we),
      .host_wdata_i(host_wdata_i),
      .cop_we_i    (cop_we),
      .cop_wdata_i (cop_wdata_i),
      .clr_i       (clr[g]),
      .in_q_o      (inb_q[g]),
      .out_q_o     (outb_q[g])
    );
  end

  assign cop_hit_o    = cop_hit;
  assign cop_rdata_o  = (cop_rd_i && cop_hit) ? inb_q[cop_idx] : '0;
  assign host_rdata_o = host_rd_i ? outb_q[host_sel_i] : '0;
endmodule

// File: rtl/mbox_checker.sv
module mbox_checker #(
  parameter int unsigned N_PORTS = 4,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned CTRL_W = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h00F4,
  localparam int unsigned SEL_W = $clog2(N_PORTS)
) (
  input logic                           clk_i,
  input logic                           rst_ni,
  input logic [ADDR_W-1:0]              cop_addr_i,
  input logic                           cop_rd_i,
  input logic                           cop_wr_i,
  input logic [DATA_W-1:0]              cop_wdata_i,
  input logic [DATA_W-1:0]              cop_rdata_o,
  input logic [SEL_W-1:0]               host_sel_i,
  input logic                           host_rd_i,
  input logic                           host_wr_i,
  input logic [DATA_W-1:0]              host_wdata_i,
  input logic [DATA_W-1:0]              host_rdata_o,
  input logic                           ctrl_wr_i,
  input logic [CTRL_W-1:0]              ctrl_data_i,
  input logic [N_PORTS-1:0][DATA_W-1:0] inb_q,
  input logic [N_PORTS-1:0][DATA_W-1:0] outb_q
);
  logic in_win;
  logic [N_PORTS-1:0] clr_req;
  assign in_win = (cop_addr_i >= BASE_ADDR) && (cop_addr_i < BASE_ADDR + ADDR_W'(N_PORTS));

  for (genvar g = 0; g < N_PORTS; g++) begin : g_port
    localparam int unsigned BIT = mbox_pkg::clr_bit_for(g, N_PORTS);
    assign clr_req[g] = ctrl_wr_i && ctrl_data_i[BIT];

    AST_CLEAR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_req[g] |=> inb_q[g] == '0);  // R6 R8
    AST_INBOUND_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(host_wr_i && host_sel_i == SEL_W'(g)) && !clr_req[g] |=> $stable(inb_q[g]));  // R7
  end

  AST_HOST_WR_LAND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_wr_i && !clr_req[host_sel_i] |=> inb_q[$past(host_sel_i)] == $past(host_wdata_i));  // R3
  AST_COP_WR_LAND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cop_wr_i && in_win |=> outb_q[$past(cop_addr_i[SEL_W-1:0])] == $past(cop_wdata_i));  // R2
  AST_OUTBOUND_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cop_wr_i && in_win) |=> $stable(outb_q));  // R4
  AST_HOST_RD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !host_rd_i |-> host_rdata_o == '0);  // R9
  AST_COP_RD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cop_rd_i && in_win) |-> cop_rdata_o == '0);  // R9
endmodule

bind audio_mailbox mbox_checker #(
  .N_PORTS  (N_PORTS),
  .DATA_W   (DATA_W),
  .ADDR_W   (ADDR_W),
  .CTRL_W   (CTRL_W),
  .BASE_ADDR(BASE_ADDR)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cop_addr_i  (cop_addr_i),
  .cop_rd_i    (cop_rd_i),
  .cop_wr_i    (cop_wr_i),
  .cop_wdata_i (cop_wdata_i),
  .cop_rdata_o (cop_rdata_o),
  .host_sel_i  (host_sel_i),
  .host_rd_i   (host_rd_i),
  .host_wr_i   (host_wr_i),
  .host_wdata_i(host_wdata_i),
  .host_rdata_o(host_rdata_o),
  .ctrl_wr_i   (ctrl_wr_i),
  .ctrl_data_i (ctrl_data_i),
  .inb_q       (inb_q),
  .outb_q      (outb_q)
);

// File: tb/audio_mailbox_tb.sv
module audio_mailbox_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cop_addr = 16'h0;
  logic        cop_rd = 1'b0, cop_wr = 1'b0;
  logic [7:0]  cop_wdata = 8'h0;
  logic [7:0]  cop_rdata;
  logic        cop_hit;
  logic [1:0]  host_sel = 2'd0;
  logic        host_rd = 1'b0, host_wr = 1'b0;
  logic [7:0]  host_wdata = 8'h0;
  logic [7:0]  host_rdata;
  logic        ctrl_wr = 1'b0;
  logic [7:0]  ctrl_data = 8'h0;

  int total = 0;
  int bad = 0;
  logic [7:0] exp_in [4];
  logic [7:0] exp_out[4];

  always #4 clk = ~clk;  // 125 MHz

  audio_mailbox u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .cop_addr_i(cop_addr), .cop_rd_i(cop_rd), .cop_wr_i(cop_wr),
    .cop_wdata_i(cop_wdata), .cop_rdata_o(cop_rdata), .cop_hit_o(cop_hit),
    .host_sel_i(host_sel), .host_rd_i(host_rd), .host_wr_i(host_wr),
    .host_wdata_i(host_wdata), .host_rdata_o(host_rdata),
    .ctrl_wr_i(ctrl_wr), .ctrl_data_i(ctrl_data)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: act=%02h exp=%02h", req, act, exp);
    end
  endtask

  task automatic host_read(int k, output logic [7:0] v);
    host_sel = 2'(k); host_rd = 1'b1; #1;
    v = host_rdata; host_rd = 1'b0; #1;
  endtask

  task automatic cop_read(logic [15:0] a, output logic [7:0] v);
    cop_addr = a; cop_rd = 1'b1; #1;
    v = cop_rdata; cop_rd = 1'b0; #1;
  endtask

  task automatic host_write(int k, logic [7:0] d);
    host_sel = 2'(k); host_wdata = d; host_wr = 1'b1;
    tick();
    host_wr = 1'b0;
    exp_in[k] = d;
  endtask

  task automatic check_all(string req);
    logic [7:0] v;
    for (int k = 0; k < 4; k++) begin
      cop_read(16'h00F4 + 16'(k), v);  chk(req, v, exp_in[k]);
      host_read(k, v);                 chk(req, v, exp_out[k]);
    end
  endtask

  initial begin
    logic [7:0] v, v2;
    for (int k = 0; k < 4; k++) begin exp_in[k] = 8'h00; exp_out[k] = 8'h00; end
    #2;
    check_all("R1");  // during reset
    tick(); tick();
    rst_n = 1'b1;
    tick();
    check_all("R1");

    // R3 R5: host writes across ports and patterns
    for (int k = 0; k < 4; k++) begin
      for (int p = 0; p < 6; p++) begin
        logic [7:0] d;
        d = (p == 0) ? 8'hFF : (p == 1) ? 8'h00 : 8'((k * 37 + p * 91 + 5) & 8'hFF);
        host_write(k, d);
        check_all("R3/R5");
      end
    end

    // R2 R4 R5: coprocessor writes across and around the window
    for (int a = 0; a < 20; a++) begin
      logic [15:0] addr;
      logic [7:0]  d;
      logic        inwin;
      addr = (a < 16) ? 16'h00F0 + 16'(a) : (a == 16) ? 16'h01F4 : (a == 17) ? 16'h80F5
           : (a == 18) ? 16'h00F8 : 16'h00B6;
      d = addr[7:0] ^ 8'h3C ^ 8'(a);
      inwin = (addr >= 16'h00F4) && (addr <= 16'h00F7);
      cop_addr = addr; #1;
      chk("R4 hit", {7'd0, cop_hit}, {7'd0, inwin});
      cop_wdata = d; cop_wr = 1'b1;
      tick();
      cop_wr = 1'b0;
      if (inwin) exp_out[addr[1:0]] = d;
      check_all("R2/R4/R5");
    end

    // R10: repeated reads
    for (int k = 0; k < 4; k++) begin
      host_read(k, v); host_read(k, v2);
      chk("R10 host reread", v2, v);
      cop_read(16'h00F4 + 16'(k), v); cop_read(16'h00F4 + 16'(k), v2);
      chk("R10 cop reread", v2, v);
    end

    // R6 R7: every clear pattern with the other control bits set
    for (int pat = 0; pat < 4; pat++) begin
      for (int k = 0; k < 4; k++) host_write(k, 8'(8'h81 + k * 17 + pat));
      ctrl_data = 8'(8'hCF | (pat << 4)); ctrl_wr = 1'b1;
      tick();
      ctrl_wr = 1'b0;
      if (pat[0]) begin exp_in[0] = 8'h00; exp_in[1] = 8'h00; end
      if (pat[1]) begin exp_in[2] = 8'h00; exp_in[3] = 8'h00; end
      check_all("R6");
      tick();
      check_all("R7 no lingering clear");
      host_write(pat, 8'h77);
      check_all("R7 write after clear");
    end

    // R8: host write colliding with each clear pattern
    for (int k = 0; k < 4; k++) begin
      for (int pat = 0; pat < 4; pat++) begin
        host_write(k, 8'hC3);
        host_sel = 2'(k); host_wdata = 8'h5A; host_wr = 1'b1;
        ctrl_data = 8'(pat << 4); ctrl_wr = 1'b1;
        tick();
        host_wr = 1'b0; ctrl_wr = 1'b0;
        exp_in[k] = 8'h5A;
        if (pat[0]) begin exp_in[0] = 8'h00; exp_in[1] = 8'h00; end
        if (pat[1]) begin exp_in[2] = 8'h00; exp_in[3] = 8'h00; end
        check_all("R8");
      end
    end

    // R9: idle and out-of-window reads
    for (int k = 0; k < 4; k++) host_write(k, 8'hE1 + 8'(k));
    for (int k = 0; k < 4; k++) begin
      host_sel = 2'(k); host_rd = 1'b0; #1;
      chk("R9 host idle", host_rdata, 8'h00);
      cop_addr = 16'h00F4 + 16'(k); cop_rd = 1'b0; #1;
      chk("R9 cop idle", cop_rdata, 8'h00);
      cop_read(16'h01F4 + 16'(k), v);
      chk("R9 cop outside", v, 8'h00);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 150000);
    total++; bad++;
    $display("FAIL watchdog: act=running exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule